// File: doc/BRIEF.md
# ATA PIO strobe timing sequencer

This block drives the host side of an ATA programmed-I/O bus. A host-side request names the access class (8-bit task-file register or 16-bit data register), the target device (master or slave), the register group (command or control block), the register address, the direction, and for writes the data. The sequencer then runs the access on the pins. It drives chip select and address with one setup cycle. It holds the read or write strobe low for a programmed number of clocks and then keeps select, address and write data for a hold period. Last, it releases the bus for a recovery period before it takes the next request.

Strobe and recovery widths come from four per-device tables, two for each access class. A single hold count serves every class. All of these values are sampled when a request is accepted. The device can stretch the strobe by pulling its ready line low. An optional timeout ends such a stall and sets a sticky interrupt flag that the host clears.

Top module: `pio_strobe_seq`

## Requirements
- R1: After reset `req_ready_o` is 1, `cs_n_o` is 2'b11, `rd_n_o` and `wr_n_o` are 1, and `dd_oe_o`, `done_o` and `tmo_irq_o` are 0.
- R2: A request is taken only at a clock edge where `req_ready_o` and `req_valid_i` are both 1, and `req_ready_o` is 1 only when the bus is idle. Exactly one cycle with chip select active and both strobes high comes before the strobe falls. Requests presented while busy have no effect on the running access.
- R3: While an access holds the bus, `cs_n_o` is 2'b10 when `req_ctl_i` was 0 (command group) and 2'b01 when it was 1 (control group). `addr_o` equals the accepted address. Both stay stable from setup through hold.
- R4: With `iordy_i` high, the strobe is low for max(S,1) cycles. S comes from `dt_stb_i` when `req_wide_i`=1 and from `tf_stb_i` when it is 0, at index 0 for `req_dev_i`=0 (master) and index 1 for 1 (slave).
- R5: After the strobe rises, chip select, address and write data are held, with both strobes high, for max(`hold_i`,1) cycles.
- R6: Then `cs_n_o` is 2'b11 for max(R,1) cycles before `req_ready_o` returns. R comes from `dt_rcv_i`/`tf_rcv_i`, chosen as in R4.
- R7: On a read, `rdata_o` takes `dd_i` as sampled at the edge where `rd_n_o` rises. A task-file read returns only bits 7:0, with zero above. Writes leave `rdata_o` unchanged.
- R8: On a write, `dd_oe_o` is 1 exactly while chip select is active, and `dd_o` is the write data (task-file: bits 7:0 with zero above). On a read `dd_oe_o` stays 0. Only the strobe matching the direction ever goes low.
- R9: While `iordy_i` is low once the strobe has reached its programmed width, the strobe stays low. If ready returns by the end of low cycle L, the strobe is low for max(S,L) cycles.
- R10: With `tmo_i`=T≠0, if ready is still low at the end of the T-th stalled cycle, the strobe rises after S+T-1 low cycles and `tmo_irq_o` is set. When T=0 no timeout occurs.
- R11: `tmo_irq_o` stays set until `tmo_clr_i` is sampled high. `done_o` is a one-cycle pulse in the first idle cycle after recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request |
| req_ready_o | output | 1 | Sequencer idle, request taken on this edge |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wide_i | input | 1 | 1 = 16-bit data register, 0 = 8-bit task file |
| req_dev_i | input | 1 | 0 = master timing, 1 = slave timing |
| req_ctl_i | input | 1 | 0 = command group, 1 = control group |
| req_addr_i | input | ADDR_W | Register address |
| req_wdata_i | input | DATA_W | Write data |
| done_o | output | 1 | Access finished pulse |
| rdata_o | output | DATA_W | Last read data |
| tf_stb_i | input | 2×CNT_W | Task-file strobe width per device |
| tf_rcv_i | input | 2×CNT_W | Task-file recovery width per device |
| dt_stb_i | input | 2×CNT_W | Data strobe width per device |
| dt_rcv_i | input | 2×CNT_W | Data recovery width per device |
| hold_i | input | CNT_W | Shared hold width |
| tmo_i | input | TMO_W | Ready timeout, 0 = off |
| tmo_clr_i | input | 1 | Clear timeout flag |
| tmo_irq_o | output | 1 | Sticky timeout flag |
| iordy_i | input | 1 | Device ready, low = stretch strobe |
| cs_n_o | output | 2 | Active-low group selects |
| addr_o | output | ADDR_W | Register address to device |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| dd_o | output | DATA_W | Data bus out |
| dd_oe_o | output | 1 | Data bus drive enable |
| dd_i | input | DATA_W | Data bus in |

## Verification
The assertions assume that `tmo_i` does not change while the strobe is stalled. They also assume that request fields have defined values whenever `req_valid_i` is high. The timing tables and hold count may change freely, because the design samples them only at acceptance. The bench follows these rules. It rewrites the timing inputs only while the sequencer is idle and keeps `tmo_i` fixed for the whole of each access. It moves `iordy_i` only inside a low-strobe cycle, between clock edges.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
  localparam int unsigned N_DEV = 2;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_RECOV  = 3'd4
  } seq_state_e;

  localparam logic [1:0] CS_CMD_N = 2'b10;
  localparam logic [1:0] CS_CTL_N = 2'b01;
  localparam logic [1:0] CS_OFF_N = 2'b11;
endpackage

// File: rtl/pio_timing_sel.sv
module pio_timing_sel
  import pio_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                       wide_i,
  input  logic                       dev_i,
  input  logic [N_DEV-1:0][CNT_W-1:0] tf_stb_i,
  input  logic [N_DEV-1:0][CNT_W-1:0] tf_rcv_i,
  input  logic [N_DEV-1:0][CNT_W-1:0] dt_stb_i,
  input  logic [N_DEV-1:0][CNT_W-1:0] dt_rcv_i,
  output logic [CNT_W-1:0]           stb_len_o,
  output logic [CNT_W-1:0]           rcv_len_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [N_DEV-1:0][CNT_W-1:0] stb_c, rcv_c;

  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    logic [CNT_W-1:0] s_raw, r_raw;
    assign s_raw    = wide_i ? dt_stb_i[d] : tf_stb_i[d];
    assign r_raw    = wide_i ? dt_rcv_i[d] : tf_rcv_i[d];
    // zero programs the minimum width of one clock
    assign stb_c[d] = (s_raw == '0) ? ONE : s_raw;
    assign rcv_c[d] = (r_raw == '0) ? ONE : r_raw;
  end

  assign stb_len_o = stb_c[dev_i];
  assign rcv_len_o = rcv_c[dev_i];
endmodule

// File: rtl/pio_phase_ctr.sv
module pio_phase_ctr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim    = CNT_W'(len_i - 1'b1);
  assign last_o = (cnt_q >= lim);

  // saturates at the last count: a stalled strobe parks here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (!last_o) cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_i != '0) |-> (cnt_q <= lim)); // R4
endmodule

// File: rtl/pio_wait_mon.sv
module pio_wait_mon #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             stall_i,
  input  logic [TMO_W-1:0] tmo_i,
  input  logic             clr_i,
  output logic             expire_o,
  output logic             irq_o
);
  logic [TMO_W-1:0] wcnt_q;
  logic             irq_q;
  logic             tmo_on;

  assign tmo_on   = (tmo_i != '0);
  assign expire_o = stall_i && tmo_on && (wcnt_q == TMO_W'(tmo_i - 1'b1));
  assign irq_o    = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            wcnt_q <= '0;
    else if (!arm_i)                        wcnt_q <= '0;
    else if (stall_i && tmo_on && !expire_o) wcnt_q <= wcnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       irq_q <= 1'b0;
    else if (expire_o) irq_q <= 1'b1;
    else if (clr_i)    irq_q <= 1'b0;
  end

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !clr_i |=> irq_q); // R11
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(stall_i && tmo_i != '0)); // R10
endmodule

// File: rtl/pio_strobe_seq.sv
module pio_strobe_seq
  import pio_seq_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned TMO_W  = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic                        req_write_i,
  input  logic                        req_wide_i,
  input  logic                        req_dev_i,
  input  logic                        req_ctl_i,
  input  logic [ADDR_W-1:0]           req_addr_i,
  input  logic [DATA_W-1:0]           req_wdata_i,
  output logic                        done_o,
  output logic [DATA_W-1:0]           rdata_o,
  input  logic [N_DEV-1:0][CNT_W-1:0] tf_stb_i,
  input  logic [N_DEV-1:0][CNT_W-1:0] tf_rcv_i,
  input  logic [N_DEV-1:0][CNT_W-1:0] dt_stb_i,
  input  logic [N_DEV-1:0][CNT_W-1:0] dt_rcv_i,
  input  logic [CNT_W-1:0]            hold_i,
  input  logic [TMO_W-1:0]            tmo_i,
  input  logic                        tmo_clr_i,
  output logic                        tmo_irq_o,
  input  logic                        iordy_i,
  output logic [1:0]                  cs_n_o,
  output logic [ADDR_W-1:0]           addr_o,
  output logic                        rd_n_o,
  output logic                        wr_n_o,
  output logic [DATA_W-1:0]           dd_o,
  output logic                        dd_oe_o,
  input  logic [DATA_W-1:0]           dd_i
);
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned UPR_W  = DATA_W - BYTE_W;

  seq_state_e state_q, state_d;
  logic [CNT_W-1:0]  stb_q, rcv_q, hold_q, phase_len;
  logic [CNT_W-1:0]  stb_sel, rcv_sel;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              write_q, ctl_q, done_q;
  logic              accept, last, stall, expire, adv, bus_act, strobe_n;

  pio_timing_sel #(.CNT_W(CNT_W)) u_sel (
    .wide_i   (req_wide_i),
    .dev_i    (req_dev_i),
    .tf_stb_i (tf_stb_i),
    .tf_rcv_i (tf_rcv_i),
    .dt_stb_i (dt_stb_i),
    .dt_rcv_i (dt_rcv_i),
    .stb_len_o(stb_sel),
    .rcv_len_o(rcv_sel)
  );

  always_comb begin
    case (state_q)
      ST_STROBE: phase_len = stb_q;
      ST_HOLD:   phase_len = hold_q;
      ST_RECOV:  phase_len = rcv_q;
      default:   phase_len = CNT_W'(1);
    endcase
  end

  pio_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (adv),
    .len_i (phase_len),
    .last_o(last)
  );

  assign stall = (state_q == ST_STROBE) && last && !iordy_i;

  pio_wait_mon #(.TMO_W(TMO_W)) u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (state_q == ST_STROBE),
    .stall_i (stall),
    .tmo_i   (tmo_i),
    .clr_i   (tmo_clr_i),
    .expire_o(expire),
    .irq_o   (tmo_irq_o)
  );

  assign accept = (state_q == ST_IDLE) && req_valid_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (req_valid_i) state_d = ST_SETUP;
      ST_SETUP:  if (last) state_d = ST_STROBE;
      ST_STROBE: if (last && (iordy_i || expire)) state_d = ST_HOLD;
      ST_HOLD:   if (last) state_d = ST_RECOV;
      ST_RECOV:  if (last) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign adv = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // timing, target and data are frozen for the whole access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q   <= CNT_W'(1);
      rcv_q   <= CNT_W'(1);
      hold_q  <= CNT_W'(1);
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      ctl_q   <= 1'b0;
    end else if (accept) begin
      stb_q   <= stb_sel;
      rcv_q   <= rcv_sel;
      hold_q  <= (hold_i == '0) ? CNT_W'(1) : hold_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wide_i ? req_wdata_i : {{UPR_W{1'b0}}, req_wdata_i[BYTE_W-1:0]};
      write_q <= req_write_i;
      ctl_q   <= req_ctl_i;
    end
  end

  logic wide_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wide_q <= 1'b0;
    else if (accept) wide_q <= req_wide_i;
  end

  // read data taken on the edge that negates the strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (state_q == ST_STROBE && state_d == ST_HOLD && !write_q)
        rdata_q <= wide_q ? dd_i : {{UPR_W{1'b0}}, dd_i[BYTE_W-1:0]};
      done_q <= (state_q == ST_RECOV) && (state_d == ST_IDLE);
    end
  end

  assign bus_act     = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
  assign req_ready_o = (state_q == ST_IDLE);
  assign cs_n_o      = bus_act ? (ctl_q ? CS_CTL_N : CS_CMD_N) : CS_OFF_N;
  assign addr_o      = addr_q;
  assign rd_n_o      = !((state_q == ST_STROBE) && !write_q);
  assign wr_n_o      = !((state_q == ST_STROBE) && write_q);
  assign dd_o        = wdata_q;
  assign dd_oe_o     = bus_act && write_q;
  assign rdata_o     = rdata_q;
  assign done_o      = done_q;
  assign strobe_n    = rd_n_o && wr_n_o;

  logic cs_act;
  assign cs_act = (cs_n_o != CS_OFF_N);

  AST_SETUP_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe_n) |-> $past(cs_act)); // R2
  AST_ACCEPT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_act) |-> $past(req_valid_i && req_ready_o)); // R2
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !cs_act && strobe_n && !dd_oe_o); // R2
  AST_BUS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_act && $past(cs_act) |-> $stable(addr_o) && $stable(cs_n_o) && $stable(dd_o)); // R3
  AST_HOLD_AFTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_n) |-> cs_act); // R5
endmodule

// File: tb/pio_strobe_seq_test.sv
module pio_strobe_seq_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic req_valid = 0, req_write = 0, req_wide = 0, req_dev = 0, req_ctl = 0;
  logic [2:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0][7:0] tf_stb = '0, tf_rcv = '0, dt_stb = '0, dt_rcv = '0;
  logic [7:0]  hold = '0;
  logic [15:0] tmo = '0;
  logic tmo_clr = 0, iordy = 1;
  logic [15:0] dd_in = '0;
  logic req_ready_o, done_o, tmo_irq_o, rd_n_o, wr_n_o, dd_oe_o;
  logic [15:0] rdata_o, dd_o;
  logic [1:0]  cs_n_o;
  logic [2:0]  addr_o;

  pio_strobe_seq uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o),
    .req_write_i(req_write), .req_wide_i(req_wide), .req_dev_i(req_dev),
    .req_ctl_i(req_ctl), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .done_o(done_o), .rdata_o(rdata_o),
    .tf_stb_i(tf_stb), .tf_rcv_i(tf_rcv), .dt_stb_i(dt_stb), .dt_rcv_i(dt_rcv),
    .hold_i(hold), .tmo_i(tmo), .tmo_clr_i(tmo_clr), .tmo_irq_o(tmo_irq_o),
    .iordy_i(iordy), .cs_n_o(cs_n_o), .addr_o(addr_o),
    .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .dd_o(dd_o), .dd_oe_o(dd_oe_o), .dd_i(dd_in)
  );

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int max1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int exp_low(input int s, input int rel, input int t);
    int nl;
    nl = (rel > s) ? rel : s;
    if (t != 0 && nl > s + t - 1) return s + t - 1;
    return nl;
  endfunction

  task automatic run_acc(input bit wide, input bit dev, input bit wr, input bit ctl,
                         input logic [2:0] a, input logic [15:0] wd, input int rel, input bit poke);
    int s, r, h, e_low, n_set, n_low, n_hold, n_rec, guard;
    bit e_irq, seen, bad_cs, bad_oe, bad_x, bad_done, cs_act, slow;
    logic [15:0] seed, lo, e_rd, e_dd, prev_rd;
    string ltag;
    s = max1(wide ? int'(dt_stb[dev]) : int'(tf_stb[dev]));
    r = max1(wide ? int'(dt_rcv[dev]) : int'(tf_rcv[dev]));
    h = max1(int'(hold));
    e_low = exp_low(s, (rel == 0) ? 1 : rel, int'(tmo));
    e_irq = (tmo != 0) && (((rel > s) ? rel : s) > s + int'(tmo) - 1);
    e_dd = wide ? wd : {8'h00, wd[7:0]};
    seed = 16'($urandom);
    n_set = 0; n_low = 0; n_hold = 0; n_rec = 0; guard = 0;
    seen = 0; bad_cs = 0; bad_oe = 0; bad_x = 0; bad_done = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_wide = wide; req_dev = dev; req_ctl = ctl;
    req_addr = a; req_wdata = wd; iordy = (rel == 0);
    while (!req_ready_o && guard < 1000) begin @(negedge clk); guard++; end
    prev_rd = rdata_o;
    @(negedge clk);
    req_valid = poke;
    if (poke) begin req_addr = ~a; req_ctl = ~ctl; req_wide = ~wide; req_write = ~wr; end
    while (!req_ready_o && guard < 4000) begin
      cs_act = (cs_n_o != 2'b11);
      slow = wr ? !wr_n_o : !rd_n_o;
      if (wr ? !rd_n_o : !wr_n_o) bad_x = 1;
      if (done_o) bad_done = 1;
      if (cs_act && (cs_n_o != (ctl ? 2'b01 : 2'b10) || addr_o != a)) bad_cs = 1;
      if (dd_oe_o != (wr && cs_act)) bad_oe = 1;
      if (wr && dd_oe_o && dd_o != e_dd) bad_oe = 1;
      if (slow) begin
        n_low++; seen = 1;
        if (!cs_act) bad_cs = 1;
        dd_in = seed + 16'(n_low);
        if (n_low == rel) iordy = 1;
      end else if (cs_act) begin
        if (seen) begin n_hold++; dd_in = ~seed; end
        else n_set++;
      end else n_rec++;
      @(negedge clk); guard++;
    end
    req_valid = 0;
    iordy = 1;
    lo = seed + 16'(e_low);
    e_rd = wide ? lo : {8'h00, lo[7:0]};
    ltag = (rel > 0) ? (e_irq ? "R10 stalled strobe width" : "R9 stalled strobe width") : "R4 strobe width";
    chk(done_o == 1'b1 && !bad_done, "R11 done pulse", {31'd0, done_o}, 32'd1);
    chk(n_set == 1, "R2 setup cycles", n_set, 1);
    chk(n_low == e_low, ltag, n_low, e_low);
    chk(n_hold == h, "R5 hold cycles", n_hold, h);
    chk(n_rec == r, "R6 recovery cycles", n_rec, r);
    chk(!bad_cs, poke ? "R2 busy request ignored" : "R3 select and address", {31'd0, bad_cs}, 32'd0);
    chk(!bad_oe && !bad_x, "R8 data drive and strobe", {30'd0, bad_oe, bad_x}, 32'd0);
    if (wr) chk(rdata_o == prev_rd, "R7 write keeps read data", rdata_o, prev_rd);
    else    chk(rdata_o == e_rd, "R7 read capture", rdata_o, e_rd);
    chk(tmo_irq_o == e_irq, "R10 timeout flag", {31'd0, tmo_irq_o}, {31'd0, e_irq});
    if (tmo_irq_o) begin
      repeat (2) @(negedge clk);
      chk(tmo_irq_o == 1'b1, "R11 flag sticky", {31'd0, tmo_irq_o}, 32'd1);
      tmo_clr = 1;
      @(negedge clk);
      tmo_clr = 0;
      chk(tmo_irq_o == 1'b0, "R11 flag clear", {31'd0, tmo_irq_o}, 32'd0);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a7a));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready_o == 1, "R1 ready", {31'd0, req_ready_o}, 32'd1);
    chk(cs_n_o == 2'b11, "R1 selects", {30'd0, cs_n_o}, 32'd3);
    chk(rd_n_o && wr_n_o, "R1 strobes", {30'd0, rd_n_o, wr_n_o}, 32'd3);
    chk(!dd_oe_o && !done_o && !tmo_irq_o, "R1 enables", {29'd0, dd_oe_o, done_o, tmo_irq_o}, 32'd0);

    // minimum widths from zero programming
    run_acc(0, 0, 0, 0, 3'd5, 16'h0, 0, 0);
    run_acc(1, 1, 1, 1, 3'd0, 16'hbeef, 0, 0);
    // class and device selection with distinct tables
    tf_stb = {8'd3, 8'd2}; tf_rcv = {8'd4, 8'd5}; dt_stb = {8'd6, 8'd7}; dt_rcv = {8'd2, 8'd3};
    hold = 8'd2;
    run_acc(0, 0, 0, 0, 3'd1, 16'h0, 0, 0);
    run_acc(0, 1, 1, 1, 3'd6, 16'h12a5, 0, 0);
    run_acc(1, 0, 0, 0, 3'd0, 16'h0, 0, 0);
    run_acc(1, 1, 1, 0, 3'd0, 16'hc3c3, 0, 0);
    // ready stall without timeout
    tmo = 16'd0;
    run_acc(1, 1, 0, 0, 3'd2, 16'h0, 9, 0);
    // timeout fires
    tmo = 16'd3;
    run_acc(0, 0, 0, 1, 3'd4, 16'h0, 250, 0);
    // release on the last permitted cycle: no timeout
    run_acc(0, 0, 0, 0, 3'd4, 16'h0, 4, 0);
    // timeout of one stalled cycle
    tmo = 16'd1;
    run_acc(1, 0, 1, 0, 3'd7, 16'h5a5a, 250, 0);
    tmo = 16'd0;
    // request held high while busy
    run_acc(1, 0, 1, 0, 3'd3, 16'h0f0f, 0, 1);
    run_acc(0, 1, 0, 1, 3'd2, 16'h0, 3, 1);

    for (int i = 0; i < 60; i++) begin
      for (int d = 0; d < 2; d++) begin
        tf_stb[d] = 8'($urandom_range(0, 6));
        tf_rcv[d] = 8'($urandom_range(0, 6));
        dt_stb[d] = 8'($urandom_range(0, 6));
        dt_rcv[d] = 8'($urandom_range(0, 6));
      end
      hold = 8'($urandom_range(0, 3));
      tmo  = 16'($urandom_range(0, 5));
      run_acc(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom),
              16'($urandom), ($urandom_range(0, 1) == 0) ? 0 : int'($urandom_range(1, 12)),
              1'($urandom_range(0, 3) == 0));
    end
    summary();
    $finish;
  end
endmodule